// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This block classifies I/O-space accesses for the legacy two-port PCI configuration mechanism. Each access comes in on a valid/ready request stream and carries a port number, an access size in bytes, a read/write flag and write data. The block holds the 32-bit configuration-address register. It decodes each access to one of four targets and emits one result item per request on a valid/ready result stream. The targets are the address register, configuration space, plain I/O and a bad-port error. The configuration-space back end and the I/O fabric sit downstream and act on the routed item.

An access to the data window (ports 0xCFC to 0xCFF) becomes a configuration-space address only while the register's enable bit is set. That address keeps bit 31 at zero, takes bits 30:2 from the register and takes bits 1:0 from the low port bits. While the enable bit is clear, the same access passes through as ordinary I/O.

Back-pressure rules: a request transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result slot is empty or is being drained in the same cycle. A result transfers when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every result field holds still. Each accepted request yields exactly one result, in order, one cycle after acceptance.

Top module: `pcicfg_port_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and the configuration-address register is zero, so a 4-byte read of port 0xCF8 returns 0 on `out_data`.
- R2: A port number with any bit above bit 15 set gives target 3 (bad port), with `out_addr` equal to the full port number. Such an access never changes the address register.
- R3: A 4-byte access to port 0xCF8 gives target 1 (address register) with `out_addr` = 0xCF8. A read returns the register value on `out_data`. A write loads `in_wdata` into the register, and the new value is seen by the next accepted access.
- R4: An access to port 0xCF8 with a size other than 4 gives target 0 (plain I/O) with `out_addr` = 0xCF8, and leaves the register unchanged.
- R5: An access to any port 0xCFC to 0xCFF while register bit 31 is 1 gives target 2 (configuration space). Its `out_addr` is {1'b0, register[30:2], port[1:0]}.
- R6: An access to 0xCFC to 0xCFF while register bit 31 is 0 gives target 0 with `out_addr` equal to the port number.
- R7: Any other in-range port gives target 0 with `out_addr` equal to the port number. For every target except a register read, `out_data` carries `in_wdata` and `out_write` carries `in_write`.
- R8: Results come out one cycle after acceptance, in request order. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_target`, `out_addr` and `out_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request may transfer |
| in_port | input | 32 | I/O port number |
| in_size | input | 3 | Access size in bytes (1, 2 or 4) |
| in_write | input | 1 | 1 = write, 0 = read |
| in_wdata | input | 32 | Write data |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result may transfer |
| out_target | output | 2 | 0 plain I/O, 1 address register, 2 config space, 3 bad port |
| out_addr | output | 32 | Formed address |
| out_data | output | 32 | Register value on register reads, otherwise write data |
| out_write | output | 1 | Copy of the request's read/write flag |

## Verification
The hardest situation to reach is a register write immediately followed by a data-window access while the result stream is stalled. Here the second request is held at the input, and it must be decoded against the freshly written register, not the old one. The stimulus reaches this case by issuing writes and window accesses back to back while the monitor withholds `out_ready` in an irregular pattern. Register reads placed after rejected writes (wrong size, out-of-range port) show through the normal result stream that the register was left alone.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  typedef enum logic [1:0] {
    TGT_IO  = 2'd0,
    TGT_REG = 2'd1,
    TGT_CFG = 2'd2,
    TGT_BAD = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e        target;
    logic [31:0] addr;
    logic [31:0] data;
    logic        write;
  } result_t;
endpackage

// File: rtl/pcicfg_addr_reg.sv
module pcicfg_addr_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
  end

  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(value));
endmodule

// File: rtl/pcicfg_route.sv
module pcicfg_route
  import pcicfg_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          IO_W      = 16,
  parameter logic [15:0] ADDR_PORT = 16'hCF8,
  parameter logic [15:0] DATA_BASE = 16'hCFC
) (
  input  logic [DATA_W-1:0] port,
  input  logic [2:0]        size,
  input  logic              write,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cfg_q,
  output result_t           res,
  output logic              reg_load
);
  localparam int EN_BIT = DATA_W - 1;

  logic out_of_range, hit_addr, hit_win;

  assign out_of_range = |port[DATA_W-1:IO_W];
  assign hit_addr     = (port[IO_W-1:0] == ADDR_PORT) && (size == 3'd4);
  assign hit_win      = (port[IO_W-1:2] == DATA_BASE[IO_W-1:2]);

  always_comb begin
    res.target = TGT_IO;
    res.addr   = port;
    res.data   = wdata;
    res.write  = write;
    reg_load   = 1'b0;
    if (out_of_range) begin
      res.target = TGT_BAD;
    end else if (hit_addr) begin
      res.target = TGT_REG;
      reg_load   = write;
      if (!write) res.data = cfg_q;
    end else if (hit_win && cfg_q[EN_BIT]) begin
      res.target = TGT_CFG;
      res.addr   = {1'b0, cfg_q[EN_BIT-1:2], port[1:0]};
    end
  end
endmodule

// File: rtl/pcicfg_port_decoder.sv
module pcicfg_port_decoder
  import pcicfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_port,
  input  logic [2:0]        in_size,
  input  logic              in_write,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_target,
  output logic [DATA_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_write
);
  logic              accept, reg_load;
  logic [DATA_W-1:0] cfg_q;
  result_t           dec, held;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  pcicfg_addr_reg #(.DATA_W(DATA_W)) u_areg (
    .clk(clk), .rst_n(rst_n),
    .load(accept && reg_load), .load_val(in_wdata), .value(cfg_q)
  );

  pcicfg_route #(.DATA_W(DATA_W), .IO_W(IO_W)) u_route (
    .port(in_port), .size(in_size), .write(in_write), .wdata(in_wdata),
    .cfg_q(cfg_q), .res(dec), .reg_load(reg_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) held <= dec;
    end
  end

  assign out_target = held.target;
  assign out_addr   = held.addr;
  assign out_data   = held.data;
  assign out_write  = held.write;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr)
      && $stable(out_target) && $stable(out_data));

  // R2
  bad_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (|in_port[DATA_W-1:IO_W]) |=> out_target == TGT_BAD);

  // R5
  window_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_port[DATA_W-1:2] == 30'h33F |=>
      (out_target == TGT_CFG || out_target == TGT_IO));

  // R8
  one_per_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
endmodule

// File: tb/test_pcicfg_port_decoder.sv
module test_pcicfg_port_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_port = '0;
  logic [2:0]  in_size = 3'd4;
  logic        in_write = 1'b0;
  logic [31:0] in_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_target;
  logic [31:0] out_addr, out_data;
  logic        out_write;

  int total = 0, bad = 0;
  logic [31:0] model_reg = '0;
  logic [65:0] expq[$];
  string       tagq[$];
  int          cyc = 0;

  always #10 clk = ~clk;

  pcicfg_port_decoder i_pcicfg_port_decoder (.*);

  task automatic check(string tag, logic [65:0] act, logic [65:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(string tag, logic [31:0] p, logic [2:0] s, logic w, logic [31:0] d);
    logic [1:0]  t;
    logic [31:0] a, od;
    t = 2'd0; a = p; od = d;
    if (p[31:16] != 0) t = 2'd3;
    else if (p[15:0] == 16'hCF8 && s == 3'd4) begin
      t = 2'd1;
      if (!w) od = model_reg;
    end else if (p[15:2] == 14'h33F && model_reg[31]) begin
      t = 2'd2;
      a = {1'b0, model_reg[30:2], p[1:0]};
    end
    @(negedge clk); #1;
    in_valid = 1'b1; in_port = p; in_size = s; in_write = w; in_wdata = d;
    while (!in_ready) begin @(negedge clk); #1; end
    expq.push_back({t, a, od});
    tagq.push_back(tag);
    if (t == 2'd1 && w) model_reg = d;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  logic        stall_seen = 1'b0;
  logic [65:0] stall_val;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc % 5 != 2) && (cyc % 7 != 3);
      if (stall_seen) begin
        check("R8 stall hold", {out_target, out_addr, out_data}, stall_val);
        stall_seen = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check("R8 extra result", 66'h1, 66'h0);
        else check(tagq.pop_front(), {out_target, out_addr, out_data}, expq.pop_front());
      end else if (out_valid) begin
        stall_seen = 1'b1;
        stall_val  = {out_target, out_addr, out_data};
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid after reset", {65'h0, out_valid}, 66'h0);
    rst_n = 1'b1;
    access("R1 R3 reset reg read", 32'hCF8, 3'd4, 1'b0, 32'h0);
    access("R6 window disabled", 32'hCFC, 3'd4, 1'b0, 32'h0);
    access("R3 reg write", 32'hCF8, 3'd4, 1'b1, 32'h8000_1234);
    access("R3 reg readback", 32'hCF8, 3'd4, 1'b0, 32'h0);
    for (int i = 0; i < 4; i++)
      access("R5 window enabled", 32'hCFC + i, 3'd1, 1'b0, 32'h0);
    access("R4 short write to CF8", 32'hCF8, 3'd2, 1'b1, 32'h0);
    access("R4 reg unchanged", 32'hCF8, 3'd4, 1'b0, 32'h0);
    access("R2 bad port write", 32'h0001_0CF8, 3'd4, 1'b1, 32'h0);
    access("R2 reg unchanged", 32'hCF8, 3'd4, 1'b0, 32'h0);
    access("R7 other port", 32'h80, 3'd1, 1'b1, 32'h5A);
    access("R7 below window", 32'hCFB, 3'd4, 1'b1, 32'hDEAD_BEEF);
    access("R7 above window", 32'hD00, 3'd4, 1'b0, 32'h0);
    access("R3 write disable", 32'hCF8, 3'd4, 1'b1, 32'h0000_00FC);
    access("R6 window after disable", 32'hCFE, 3'd2, 1'b1, 32'h77);
    access("R3 write all ones", 32'hCF8, 3'd4, 1'b1, 32'hFFFF_FFFF);
    access("R5 window all ones", 32'hCFD, 3'd1, 1'b1, 32'h12);
    for (int i = 0; i < 6; i++) begin
      access("R3 b2b write", 32'hCF8, 3'd4, 1'b1, 32'h8000_0000 | (i << 8));
      access("R5 b2b window", 32'hCFF, 3'd4, 1'b0, 32'h0);
    end
    repeat (40) @(posedge clk);
    check("R8 all results drained", {34'h0, 32'(expq.size())}, 66'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule